// File: doc/BRIEF.md
# Debug Program Buffer with Implicit Breakpoint

This block is the small instruction store inside a processor debug module. An external debugger fills it one 32-bit word at a time through a register port, and a halted hart then fetches from it, word by word, to run short instruction sequences. The block also holds a few data words that the debugger and the buffered code share. It reports the buffer size and the data word count in a read-only control/status register.

When the implicit-breakpoint option is built in, the block answers a fetch of the slot just past the last buffer word with a fixed breakpoint instruction. The debugger then does not have to end its sequence with one, and the buffer can be one word smaller. The register port decodes its own address window. A request that lands outside the implemented registers, or a fetch past the legal range, leaves a sticky error code in a status register. That code stays until the debugger writes back exactly the value it holds.

Buffer depth, data word count and the implicit-breakpoint option are elaboration parameters. A build with a single buffer word is only accepted when the option is on.

Top module: `pbuf_top`

## Requirements
- R1: A write to register address PB_BASE+i (default 0x20+i) with i below PB_WORDS (default 4) stores the word in buffer slot i. A read of that address returns it on reg_rdata one cycle after the request, with reg_rvalid high. All slots are zero after reset.
- R2: A read of the control/status register at CS_ADDR (default 0x16) returns PB_WORDS in bits 28:24 and DATA_WORDS in bits 3:0. All other bits are zero.
- R3: A read of the status register at STATUS_ADDR (default 0x11) returns the implicit-breakpoint option in bit 22 and the error code in bits 20:18. All other bits are zero.
- R4: A fetch of index i below PB_WORDS returns buffer slot i on fetch_word one cycle after fetch_req, with fetch_valid high.
- R5: With the option on, a fetch of index PB_WORDS returns 0x00100073.
- R6: A fetch at or beyond the first illegal index returns zero and raises error code 1 (unimplemented address). The first illegal index is PB_WORDS+1 with the option on and PB_WORDS with it off.
- R7: A register read outside the implemented addresses returns zero. A register write outside them changes no stored word. Either one raises error code 1.
- R8: The error code is 0 after reset. It changes only from 0 to a new code, so the first error is kept. It returns to 0 only when the status register is written with bits 20:18 equal to the code it currently holds. A clear takes priority over a new error in the same cycle.
- R9: A write to the read-only control/status register raises error code 7 (other failure) and leaves its contents unchanged.
- R10: Data word j, with j below DATA_WORDS (default 2), is read and written at DATA_BASE+j (default 0x04+j) and is zero after reset.
- R11: The error code is also driven on the err_code output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_req | input | 1 | Register access request, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Response valid, one cycle after reg_req |
| reg_rdata | output | 32 | Read data (zero for writes) |
| fetch_req | input | 1 | Hart instruction fetch request |
| fetch_idx | input | FETCH_AW | Word index of the fetch |
| fetch_valid | output | 1 | Fetch response valid, one cycle after fetch_req |
| fetch_word | output | 32 | Fetched instruction word |
| err_code | output | 3 | Sticky error code: 0 none, 1 unimplemented address, 7 other |

## Verification
The bench targets the slot just past the buffer. A design with an off-by-one boundary would either fault on the breakpoint slot or hand back stale data from one slot further on. It also probes the error field's stickiness: it tries to clear with a wrong value and raises a second error over a first one. A design that cleared on any write, or let a later error replace the first, would show the wrong code at err_code and in the status read. Writes just past the buffer window and to the read-only register are followed by read-backs of every slot and of the size field. An address decode that wraps or aliases would show up there as a corrupted word.

// File: rtl/pbuf_pkg.sv
// Package: shared constants for the debug program buffer.
// Assumes 32-bit words; bit positions match the fields software decodes.
package pbuf_pkg;
    localparam logic [31:0] BRK_INSN  = 32'h0010_0073;
    localparam int          SIZE_LSB  = 24;
    localparam int          IMPL_BIT  = 22;
    localparam int          ERR_LSB   = 18;
    localparam int          MAX_WORDS = 16;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_BADADDR = 3'd1,
        ERR_OTHER   = 3'd7
    } dm_err_e;
endpackage

// File: rtl/pbuf_words.sv
// Module: word store with one write port and all words visible.
// Assumes NWORDS may be 0; one dummy slot is kept so arrays never vanish.
module pbuf_words #(
    parameter int NWORDS = 4,
    parameter int SEL_W  = 7,
    localparam int SLOTS = (NWORDS == 0) ? 1 : NWORDS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [31:0]      wr_data,
    output logic [31:0]      words [SLOTS]
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < NWORDS) begin : g_live
            // Store one slot on a selected write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    words[g] <= '0;
                else if (wr_en && wr_sel == SEL_W'(g))
                    words[g] <= wr_data;
            end
        end else begin : g_dead
            assign words[g] = '0;
        end
    end
endmodule

// File: rtl/pbuf_fetch.sv
// Module: hart fetch port. Returns a buffer word, the implicit breakpoint
// or zero, registered one cycle after the request. Flags illegal indices.
// Assumes fetch_idx is wide enough to name PB_WORDS+1.
module pbuf_fetch
    import pbuf_pkg::*;
#(
    parameter int PB_WORDS = 4,
    parameter int IMPL_BRK = 1,
    parameter int FETCH_AW = 5,
    localparam int SLOTS = (PB_WORDS == 0) ? 1 : PB_WORDS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [31:0]         words [SLOTS],
    input  logic                fetch_req,
    input  logic [FETCH_AW-1:0] fetch_idx,
    output logic                fetch_valid,
    output logic [31:0]         fetch_word,
    output logic                fetch_bad
);
    localparam logic [FETCH_AW:0] LIMIT = (FETCH_AW+1)'(PB_WORDS);

    logic [FETCH_AW:0] idx_ext;
    logic              in_buf;
    logic              at_brk;
    logic [31:0]       buf_word;

    // Classify the requested index.
    always_comb begin
        idx_ext   = {1'b0, fetch_idx};
        in_buf    = idx_ext < LIMIT;
        at_brk    = (IMPL_BRK != 0) && (idx_ext == LIMIT);
        fetch_bad = fetch_req && !in_buf && !at_brk;
    end

    // Select the addressed buffer word.
    always_comb begin
        buf_word = '0;
        for (int i = 0; i < SLOTS; i++)
            if (fetch_idx == FETCH_AW'(i)) buf_word = words[i];
    end

    // Register the fetch response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_valid <= 1'b0;
            fetch_word  <= '0;
        end else begin
            fetch_valid <= fetch_req;
            if (fetch_req)
                fetch_word <= in_buf ? buf_word : (at_brk ? BRK_INSN : '0);
        end
    end
endmodule

// File: rtl/pbuf_regif.sv
// Module: debugger register port. Decodes the buffer and data windows,
// the status and control/status registers, and keeps the sticky error code.
// Assumes one access per request cycle; response one cycle later.
module pbuf_regif
    import pbuf_pkg::*;
#(
    parameter int                ADDR_W      = 7,
    parameter int                PB_WORDS    = 4,
    parameter int                DATA_WORDS  = 2,
    parameter int                IMPL_BRK    = 1,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 7'h11,
    parameter logic [ADDR_W-1:0] CS_ADDR     = 7'h16,
    parameter logic [ADDR_W-1:0] PB_BASE     = 7'h20,
    parameter logic [ADDR_W-1:0] DATA_BASE   = 7'h04,
    localparam int PB_SLOTS = (PB_WORDS == 0) ? 1 : PB_WORDS,
    localparam int DT_SLOTS = (DATA_WORDS == 0) ? 1 : DATA_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic [31:0]       pb_words [PB_SLOTS],
    input  logic [31:0]       dt_words [DT_SLOTS],
    input  logic              fetch_bad,
    output logic              pb_we,
    output logic              dt_we,
    output logic [ADDR_W-1:0] pb_sel,
    output logic [ADDR_W-1:0] dt_sel,
    output logic              reg_rvalid,
    output logic [31:0]       reg_rdata,
    output logic [2:0]        err_code
);
    logic        hit_pb, hit_dt, hit_st, hit_cs, hit_any;
    logic [31:0] pb_rd, dt_rd, rd_val;
    logic        clr;
    dm_err_e     new_err;

    // Decode the register address.
    always_comb begin
        pb_sel  = reg_addr - PB_BASE;
        dt_sel  = reg_addr - DATA_BASE;
        hit_pb  = (reg_addr >= PB_BASE) && (pb_sel < ADDR_W'(PB_WORDS));
        hit_dt  = (reg_addr >= DATA_BASE) && (dt_sel < ADDR_W'(DATA_WORDS));
        hit_st  = reg_addr == STATUS_ADDR;
        hit_cs  = reg_addr == CS_ADDR;
        hit_any = hit_pb || hit_dt || hit_st || hit_cs;
        pb_we   = reg_req && reg_we && hit_pb;
        dt_we   = reg_req && reg_we && hit_dt;
    end

    // Select the addressed buffer and data words.
    always_comb begin
        pb_rd = '0;
        for (int i = 0; i < PB_SLOTS; i++)
            if (pb_sel == ADDR_W'(i)) pb_rd = pb_words[i];
        dt_rd = '0;
        for (int j = 0; j < DT_SLOTS; j++)
            if (dt_sel == ADDR_W'(j)) dt_rd = dt_words[j];
    end

    // Build the read value.
    always_comb begin
        rd_val = '0;
        if (hit_pb) begin
            rd_val = pb_rd;
        end else if (hit_dt) begin
            rd_val = dt_rd;
        end else if (hit_st) begin
            rd_val[IMPL_BIT]             = (IMPL_BRK != 0);
            rd_val[ERR_LSB+2:ERR_LSB]    = err_code;
        end else if (hit_cs) begin
            rd_val[SIZE_LSB+4:SIZE_LSB]  = 5'(PB_WORDS);
            rd_val[3:0]                  = 4'(DATA_WORDS);
        end
    end

    // Work out the error raised or cleared by this cycle.
    always_comb begin
        clr = reg_req && reg_we && hit_st
              && (reg_wdata[ERR_LSB+2:ERR_LSB] == err_code);
        if (reg_req && !hit_any)
            new_err = ERR_BADADDR;
        else if (reg_req && reg_we && hit_cs)
            new_err = ERR_OTHER;
        else if (fetch_bad)
            new_err = ERR_BADADDR;
        else
            new_err = ERR_NONE;
    end

    // Register the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
        end else begin
            reg_rvalid <= reg_req;
            if (reg_req)
                reg_rdata <= reg_we ? '0 : rd_val;
        end
    end

    // Hold the first error until cleared by a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_code <= ERR_NONE;
        else if (clr)
            err_code <= ERR_NONE;
        else if (err_code == ERR_NONE && new_err != ERR_NONE)
            err_code <= new_err;
    end
endmodule

// File: rtl/pbuf_top.sv
// Module: debug program buffer top. Ties the word stores, register port
// and fetch port together and checks the build parameters.
// Assumes PB_WORDS 0..16, DATA_WORDS 1..12, size 1 only with the option on.
module pbuf_top
    import pbuf_pkg::*;
#(
    parameter int                PB_WORDS    = 4,
    parameter int                DATA_WORDS  = 2,
    parameter int                IMPL_BRK    = 1,
    parameter int                ADDR_W      = 7,
    parameter int                FETCH_AW    = 5,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 7'h11,
    parameter logic [ADDR_W-1:0] CS_ADDR     = 7'h16,
    parameter logic [ADDR_W-1:0] PB_BASE     = 7'h20,
    parameter logic [ADDR_W-1:0] DATA_BASE   = 7'h04
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_req,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic                reg_rvalid,
    output logic [31:0]         reg_rdata,
    input  logic                fetch_req,
    input  logic [FETCH_AW-1:0] fetch_idx,
    output logic                fetch_valid,
    output logic [31:0]         fetch_word,
    output logic [2:0]          err_code
);
    localparam int PB_SLOTS = (PB_WORDS == 0) ? 1 : PB_WORDS;
    localparam int DT_SLOTS = (DATA_WORDS == 0) ? 1 : DATA_WORDS;

    if (PB_WORDS > MAX_WORDS || (PB_WORDS == 1 && IMPL_BRK == 0)
        || DATA_WORDS < 1 || DATA_WORDS > 12) begin : g_bad_cfg
        $error("pbuf_top: unsupported buffer configuration");
    end

    logic [31:0]       pb_words [PB_SLOTS];
    logic [31:0]       dt_words [DT_SLOTS];
    logic              pb_we, dt_we, fetch_bad;
    logic [ADDR_W-1:0] pb_sel, dt_sel;

    pbuf_words #(.NWORDS(PB_WORDS), .SEL_W(ADDR_W)) u_pb (
        .clk(clk), .rst_n(rst_n), .wr_en(pb_we), .wr_sel(pb_sel),
        .wr_data(reg_wdata), .words(pb_words)
    );

    pbuf_words #(.NWORDS(DATA_WORDS), .SEL_W(ADDR_W)) u_dt (
        .clk(clk), .rst_n(rst_n), .wr_en(dt_we), .wr_sel(dt_sel),
        .wr_data(reg_wdata), .words(dt_words)
    );

    pbuf_regif #(
        .ADDR_W(ADDR_W), .PB_WORDS(PB_WORDS), .DATA_WORDS(DATA_WORDS),
        .IMPL_BRK(IMPL_BRK), .STATUS_ADDR(STATUS_ADDR), .CS_ADDR(CS_ADDR),
        .PB_BASE(PB_BASE), .DATA_BASE(DATA_BASE)
    ) u_regif (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pb_words(pb_words),
        .dt_words(dt_words), .fetch_bad(fetch_bad), .pb_we(pb_we),
        .dt_we(dt_we), .pb_sel(pb_sel), .dt_sel(dt_sel),
        .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata), .err_code(err_code)
    );

    pbuf_fetch #(
        .PB_WORDS(PB_WORDS), .IMPL_BRK(IMPL_BRK), .FETCH_AW(FETCH_AW)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .words(pb_words), .fetch_req(fetch_req),
        .fetch_idx(fetch_idx), .fetch_valid(fetch_valid),
        .fetch_word(fetch_word), .fetch_bad(fetch_bad)
    );
endmodule

// File: rtl/pbuf_chk.sv
// Module: protocol checker for pbuf_top, attached by bind below.
// Assumes the same parameters as the instance it watches.
module pbuf_chk
    import pbuf_pkg::*;
#(
    parameter int                PB_WORDS    = 4,
    parameter int                IMPL_BRK    = 1,
    parameter int                ADDR_W      = 7,
    parameter int                FETCH_AW    = 5,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 7'h11,
    parameter logic [ADDR_W-1:0] CS_ADDR     = 7'h16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_req,
    input logic                reg_we,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_rvalid,
    input logic [31:0]         reg_rdata,
    input logic                fetch_req,
    input logic [FETCH_AW-1:0] fetch_idx,
    input logic                fetch_valid,
    input logic [31:0]         fetch_word,
    input logic [2:0]          err_code
);
    localparam logic [FETCH_AW:0] FIRST_BAD =
        (FETCH_AW+1)'(PB_WORDS + ((IMPL_BRK != 0) ? 1 : 0));

    logic st_wr;
    assign st_wr = reg_req && reg_we && reg_addr == STATUS_ADDR;

    // R4
    fetch_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> fetch_valid);

    // R1
    reg_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |=> reg_rvalid);

    // R5
    brk_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (IMPL_BRK != 0 && fetch_req && {1'b0, fetch_idx} == (FETCH_AW+1)'(PB_WORDS))
        |=> fetch_word == BRK_INSN);

    // R6
    bad_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && {1'b0, fetch_idx} >= FIRST_BAD && !st_wr)
        |=> (fetch_word == 32'h0 && err_code != 3'd0));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 3'd0 && !st_wr) |=> err_code == $past(err_code));

    // R2
    size_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_we && reg_addr == CS_ADDR)
        |=> reg_rdata[SIZE_LSB+4:SIZE_LSB] == 5'(PB_WORDS));

    // R8
    err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_code == 3'd0 || err_code == 3'd1 || err_code == 3'd7);
endmodule

bind pbuf_top pbuf_chk #(
    .PB_WORDS(PB_WORDS), .IMPL_BRK(IMPL_BRK), .ADDR_W(ADDR_W),
    .FETCH_AW(FETCH_AW), .STATUS_ADDR(STATUS_ADDR), .CS_ADDR(CS_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .fetch_req(fetch_req), .fetch_idx(fetch_idx), .fetch_valid(fetch_valid),
    .fetch_word(fetch_word), .err_code(err_code)
);

// File: tb/sim_pbuf_top.sv
// Bench: directed corners plus seeded random traffic against a bench model.
module sim_pbuf_top;
    localparam int CLK_PERIOD = 10;
    localparam int PBW = 4;
    localparam int DW  = 2;
    localparam logic [6:0] ST  = 7'h11;
    localparam logic [6:0] CS  = 7'h16;
    localparam logic [6:0] PBB = 7'h20;
    localparam logic [6:0] DB  = 7'h04;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0, reg_we = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rvalid, fetch_valid;
    logic [31:0] reg_rdata, fetch_word;
    logic        fetch_req = 1'b0;
    logic [4:0]  fetch_idx = '0;
    logic [2:0]  err_code;

    int errors = 0, checks = 0;
    bit done = 0;
    logic [31:0] pb_m [PBW];
    logic [31:0] dt_m [DW];
    logic [2:0]  err_m = 3'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbuf_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid),
        .reg_rdata(reg_rdata), .fetch_req(fetch_req), .fetch_idx(fetch_idx),
        .fetch_valid(fetch_valid), .fetch_word(fetch_word), .err_code(err_code)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] status_val(logic [2:0] e);
        return 32'h0040_0000 | ({29'd0, e} << 18);
    endfunction

    function automatic logic [31:0] cs_val();
        return (32'(PBW) << 24) | 32'(DW);
    endfunction

    // Bench model of the error code for one register access.
    function automatic logic [2:0] next_err(logic [2:0] e, logic we,
                                            logic [6:0] a, logic [31:0] d);
        bit known = (a == ST) || (a == CS) || (a >= PBB && a < PBB + PBW)
                    || (a >= DB && a < DB + DW);
        if (we && a == ST && d[20:18] == e) return 3'd0;
        if (e != 3'd0) return e;
        if (!known) return 3'd1;
        if (we && a == CS) return 3'd7;
        return 3'd0;
    endfunction

    task automatic reg_op(logic we, logic [6:0] a, logic [31:0] d,
                          output logic [31:0] rd);
        @(negedge clk);
        reg_req = 1'b1; reg_we = we; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_req = 1'b0;
        rd = reg_rdata;
        if (we && a >= PBB && a < PBB + PBW) pb_m[a - PBB] = d;
        if (we && a >= DB && a < DB + DW) dt_m[a - DB] = d;
        err_m = next_err(err_m, we, a, d);
        check("R11 err_code", {29'd0, err_code}, {29'd0, err_m});
    endtask

    task automatic fetch_op(logic [4:0] idx, output logic [31:0] w);
        @(negedge clk);
        fetch_req = 1'b1; fetch_idx = idx;
        @(posedge clk); #1;
        fetch_req = 1'b0;
        w = fetch_word;
        if (idx > 5'(PBW) && err_m == 3'd0) err_m = 3'd1;
        check("R6 err after fetch", {29'd0, err_code}, {29'd0, err_m});
    endtask

    task automatic expect_read(string tag, logic [6:0] a, logic [31:0] exp);
        logic [31:0] rd;
        reg_op(1'b0, a, 32'h0, rd);
        check(tag, rd, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] w, rd;
        void'($urandom(32'd4242));
        for (int i = 0; i < PBW; i++) pb_m[i] = '0;
        for (int i = 0; i < DW; i++) dt_m[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // Reset state.
        check("R8 reset err", {29'd0, err_code}, 32'd0);
        expect_read("R3 status reset", ST, status_val(3'd0));
        expect_read("R2 cs fields", CS, cs_val());
        for (int i = 0; i < PBW; i++) expect_read("R1 reset slot", PBB + 7'(i), 32'h0);
        expect_read("R10 reset data", DB, 32'h0);

        // Breakpoint slot and fetch of written words.
        fetch_op(5'd4, w); check("R5 implicit brk", w, 32'h0010_0073);
        check("R4 fetch_valid", {31'd0, fetch_valid}, 32'd1);
        reg_op(1'b1, PBB + 7'd3, 32'hCAFE_0013, rd);
        fetch_op(5'd3, w); check("R4 last slot", w, 32'hCAFE_0013);

        // Fetch beyond and sticky behaviour.
        fetch_op(5'd5, w); check("R6 beyond word", w, 32'h0);
        check("R6 err badaddr", {29'd0, err_code}, 32'd1);
        reg_op(1'b1, CS, 32'hFFFF_FFFF, rd);
        check("R8 first error kept", {29'd0, err_code}, 32'd1);
        reg_op(1'b1, ST, 32'd7 << 18, rd);
        check("R8 wrong clear ignored", {29'd0, err_code}, 32'd1);
        expect_read("R3 status err", ST, status_val(3'd1));
        reg_op(1'b1, ST, 32'd1 << 18, rd);
        check("R8 matching clear", {29'd0, err_code}, 32'd0);
        fetch_op(5'd31, w); check("R6 far beyond", w, 32'h0);
        reg_op(1'b1, ST, 32'd1 << 18, rd);

        // Read-only register write.
        reg_op(1'b1, CS, 32'hFFFF_FFFF, rd);
        check("R9 err other", {29'd0, err_code}, 32'd7);
        expect_read("R9 cs unchanged", CS, cs_val());
        reg_op(1'b1, ST, 32'd7 << 18, rd);
        check("R8 clear other", {29'd0, err_code}, 32'd0);

        // Unimplemented addresses.
        expect_read("R7 unimpl read", 7'h30, 32'h0);
        check("R7 err", {29'd0, err_code}, 32'd1);
        reg_op(1'b1, ST, 32'd1 << 18, rd);
        reg_op(1'b1, PBB + 7'(PBW), 32'hDEAD_BEEF, rd);
        reg_op(1'b1, DB + 7'(DW), 32'hDEAD_BEEF, rd);
        check("R7 write err", {29'd0, err_code}, 32'd1);
        for (int i = 0; i < PBW; i++) expect_read("R7 slot intact", PBB + 7'(i), pb_m[i]);
        for (int i = 0; i < DW; i++) expect_read("R7 data intact", DB + 7'(i), dt_m[i]);
        reg_op(1'b1, ST, 32'd1 << 18, rd);

        // Random traffic.
        for (int n = 0; n < 600; n++) begin
            int kind = $urandom_range(0, 8);
            case (kind)
                0, 1: reg_op(1'b1, PBB + 7'($urandom_range(0, PBW-1)), $urandom, rd);
                2: begin
                    int k = $urandom_range(0, PBW-1);
                    expect_read("R1 random read", PBB + 7'(k), pb_m[k]);
                end
                3: reg_op(1'b1, DB + 7'($urandom_range(0, DW-1)), $urandom, rd);
                4: begin
                    int k = $urandom_range(0, DW-1);
                    expect_read("R10 random data", DB + 7'(k), dt_m[k]);
                end
                5, 6: begin
                    int k = $urandom_range(0, PBW);
                    fetch_op(5'(k), w);
                    check("R4 R5 random fetch", w, (k == PBW) ? 32'h0010_0073 : pb_m[k]);
                end
                7: expect_read("R3 random status", ST, status_val(err_m));
                default: begin
                    if ($urandom_range(0, 1) == 0) fetch_op(5'($urandom_range(PBW+1, 31)), w);
                    else reg_op(1'b1, ST, {11'd0, err_m, 18'd0}, rd);
                end
            endcase
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule